// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Controller

This block produces the interrupt flags and FIFO status for a synchronous serial port with an 8-entry transmit FIFO and an 8-entry receive FIFO. The serial datapath supplies the two FIFO occupancy counts, a one-cycle pulse for each received frame, a one-cycle pulse for each receive FIFO read, a bit-period tick and a busy level. From these the block derives four interrupt sources. Two of them follow the FIFO levels directly: receive at least half full and transmit at least half empty. The other two are sticky: receive overrun and receive timeout. A software mask gates all four. Each source can be read in raw form and in masked form.

Software reaches the block through a small register port. It has a write strobe, a 3-bit address and byte data, and reads are combinational. The register offsets are: 0 mask (read/write), 1 raw flags, 2 masked flags, 3 clear (write-only, reads 0), 4 FIFO status. In the mask, raw and masked registers the bit order is the same: bit 0 overrun, bit 1 timeout, bit 2 receive half-full, bit 3 transmit half-empty. A single registered interrupt line is the OR of the masked flags.

A state machine times receive inactivity, and it has three states:
- TMO_EMPTY: the receive FIFO holds nothing.
- TMO_COUNT: the FIFO holds data and the machine counts bit ticks.
- TMO_FIRED: the timeout has been reported.

Its transitions are:
- EMPTY to COUNT when data appears.
- COUNT or FIRED to EMPTY when the FIFO drains.
- COUNT to FIRED on the final tick.
- FIRED to COUNT on a read or a new frame.
- In COUNT, a read or a new frame restarts the count.

Top module: `spi_irq_ctrl`

## Requirements
- R1: The mask register is at offset 0 and reads back the last 4-bit value written. The mask, raw (offset 1) and masked (offset 2) registers use bit 0 overrun, bit 1 timeout, bit 2 receive half-full and bit 3 transmit half-empty. Bits 7:4 read 0.
- R2: The overrun raw flag becomes 1 on the cycle after a frame pulse that arrives while the receive level equals 8. It then stays 1 until it is cleared.
- R3: The timeout raw flag becomes 1 after TIMEOUT_BITS bit ticks (default 32). The ticks must arrive while the receive FIFO is non-empty and with no read or frame pulse between them. The count starts on the cycle after the FIFO becomes non-empty, and each read or frame pulse restarts it from zero. The flag stays 1 until it is cleared.
- R4: Raw bit 2 is 1 when the receive level is 4 or more. Raw bit 3 is 1 when the transmit free space (8 minus the level) is 4 or more. Both bits follow the inputs in the same cycle.
- R5: The masked register equals raw AND mask. The mask resets to 0.
- R6: A write to offset 3 with data bit 0 set clears overrun, and with data bit 1 set clears timeout, from the next cycle on. Data bits that are 0 leave the flags unchanged. Reads of offset 3 return 0.
- R7: When a set event and a clear write hit the same sticky flag in one cycle, the flag ends at 1.
- R8: After reset: mask is 0; raw reads 0x08 with both levels at 0; masked is 0; the interrupt output is 0.
- R9: The status register at offset 4 has these bits: bit 0 transmit level is 0, bit 1 transmit level is not 8, bit 2 receive level is not 0, bit 3 receive level is 8, bit 4 the busy input. Bits 7:5 read 0.
- R10: The interrupt output equals the OR of the masked flags, delayed by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 4 | Transmit FIFO occupancy, 0 to 8 |
| rx_level | input | 4 | Receive FIFO occupancy, 0 to 8 |
| rx_frame | input | 1 | One-cycle pulse: a frame finished arriving |
| rx_read | input | 1 | One-cycle pulse: the receive FIFO was read |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| busy | input | 1 | Serial engine busy |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | Combined interrupt, registered |

## Verification
Results fall due at different times.
- Level flags, masked bits and status bits follow the inputs in the same cycle.
- Sticky flags, mask writes and clears take effect on the first clock edge after the stimulus.
- The interrupt line lags the masked flags by one further edge.
- A timeout reports on the edge of its 32nd counted tick, which falls 33 edges after data first appears when a tick arrives every cycle.

The bench drives inputs and reads registers only between rising edges. A per-cycle model, written from the requirements, advances on each edge. All register offsets and the interrupt line are compared at every falling edge. Directed checks pin down the exact timeout edge and the clear/set collision.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    typedef enum logic [1:0] {
        TMO_EMPTY = 2'd0,
        TMO_COUNT = 2'd1,
        TMO_FIRED = 2'd2
    } tmo_state_e;

    localparam int SRC_OVR  = 0;
    localparam int SRC_TMO  = 1;
    localparam int SRC_RXH  = 2;
    localparam int SRC_TXH  = 3;
    localparam int NUM_SRC  = 4;

    localparam logic [2:0] OFS_MASK   = 3'd0;
    localparam logic [2:0] OFS_RAW    = 3'd1;
    localparam logic [2:0] OFS_MASKED = 3'd2;
    localparam logic [2:0] OFS_CLEAR  = 3'd3;
    localparam logic [2:0] OFS_STATUS = 3'd4;
endpackage

// File: rtl/spi_irq_timeout.sv
module spi_irq_timeout
    import spi_irq_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter int TIMEOUT_BITS = 32,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int CNT_W = (TIMEOUT_BITS > 1) ? $clog2(TIMEOUT_BITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_frame,
    input  logic             rx_read,
    input  logic             bit_tick,
    output logic             tmo_fire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_BITS - 1);

    tmo_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             has_data, restart;

    assign has_data = (rx_level != '0);
    assign restart  = rx_read | rx_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TMO_EMPTY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        tmo_fire = 1'b0;
        unique case (st_q)
            TMO_EMPTY: begin
                cnt_d = '0;
                if (has_data) st_d = TMO_COUNT;
            end
            TMO_COUNT: begin
                if (!has_data) begin
                    st_d  = TMO_EMPTY;
                    cnt_d = '0;
                end else if (restart) begin
                    cnt_d = '0;
                end else if (bit_tick) begin
                    if (cnt_q == LAST) begin
                        st_d     = TMO_FIRED;
                        cnt_d    = '0;
                        tmo_fire = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            TMO_FIRED: begin
                cnt_d = '0;
                if (!has_data)    st_d = TMO_EMPTY;
                else if (restart) st_d = TMO_COUNT;
            end
            default: begin
                st_d  = TMO_EMPTY;
                cnt_d = '0;
            end
        endcase
    end

    AST_FIRE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fire |-> (has_data && !restart && bit_tick)); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R3
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags
    import spi_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int HALF  = DEPTH / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic               rx_frame,
    input  logic               tmo_fire,
    input  logic               clr_ovr,
    input  logic               clr_tmo,
    output logic [NUM_SRC-1:0] raw
);
    logic ovr_q, tmo_q, ovr_set;
    logic [LVL_W-1:0] tx_free;

    assign ovr_set = rx_frame && (rx_level == LVL_W'(DEPTH));
    assign tx_free = LVL_W'(DEPTH) - tx_level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            tmo_q <= 1'b0;
        end else begin
            ovr_q <= ovr_set  | (ovr_q & ~clr_ovr);
            tmo_q <= tmo_fire | (tmo_q & ~clr_tmo);
        end
    end

    always_comb begin
        raw          = '0;
        raw[SRC_OVR] = ovr_q;
        raw[SRC_TMO] = tmo_q;
        raw[SRC_RXH] = (rx_level >= LVL_W'(HALF));
        raw[SRC_TXH] = (tx_free  >= LVL_W'(HALF));
    end

    AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> raw[SRC_OVR]); // R2
    AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[SRC_OVR] && !clr_ovr) |=> raw[SRC_OVR]); // R2
    AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovr && !ovr_set) |=> !raw[SRC_OVR]); // R6
    AST_TMO_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_fire && clr_tmo) |=> raw[SRC_TMO]); // R7
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter int TIMEOUT_BITS = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_frame,
    input  logic             rx_read,
    input  logic             bit_tick,
    input  logic             busy,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq
);
    logic [NUM_SRC-1:0] mask_q, raw, masked;
    logic               tmo_fire, clr_wr, irq_q;
    logic [4:0]         status;

    assign clr_wr = reg_we && (reg_addr == OFS_CLEAR);

    spi_irq_timeout #(.DEPTH(DEPTH), .TIMEOUT_BITS(TIMEOUT_BITS)) u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_level (rx_level),
        .rx_frame (rx_frame),
        .rx_read  (rx_read),
        .bit_tick (bit_tick),
        .tmo_fire (tmo_fire)
    );

    spi_irq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rx_frame (rx_frame),
        .tmo_fire (tmo_fire),
        .clr_ovr  (clr_wr & reg_wdata[0]),
        .clr_tmo  (clr_wr & reg_wdata[1]),
        .raw      (raw)
    );

    assign masked = raw & mask_q;
    assign status = {busy,
                     rx_level == LVL_W'(DEPTH),
                     rx_level != '0,
                     tx_level != LVL_W'(DEPTH),
                     tx_level == '0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (reg_we && reg_addr == OFS_MASK) mask_q <= reg_wdata[NUM_SRC-1:0];
            irq_q <= |masked;
        end
    end

    assign irq = irq_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_MASK:   reg_rdata[NUM_SRC-1:0] = mask_q;
            OFS_RAW:    reg_rdata[NUM_SRC-1:0] = raw;
            OFS_MASKED: reg_rdata[NUM_SRC-1:0] = masked;
            OFS_STATUS: reg_rdata[4:0]         = status;
            default:    reg_rdata              = '0;
        endcase
    end

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|masked) |=> irq); // R10
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !(|masked) |=> !irq); // R10
    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_MASK) |=> (mask_q == $past(reg_wdata[NUM_SRC-1:0]))); // R1
endmodule

// File: tb/spi_irq_ctrl_tb.sv
`timescale 1ns/1ps
module spi_irq_ctrl_tb;
    localparam int DEPTH = 8;
    localparam int TO    = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tx_level = '0, rx_level = '0;
    logic       rx_frame = 0, rx_read = 0, bit_tick = 0, busy = 0;
    logic       reg_we = 0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_irq_ctrl #(.DEPTH(DEPTH), .TIMEOUT_BITS(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .rx_frame(rx_frame), .rx_read(rx_read), .bit_tick(bit_tick), .busy(busy),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // model state
    logic [3:0] m_mask;
    logic       m_ovr, m_tmo, m_irq, m_act, m_fired;
    int         m_cnt;

    function automatic logic [3:0] exp_raw();
        logic [3:0] r;
        r[0] = m_ovr;
        r[1] = m_tmo;
        r[2] = (int'(rx_level) >= DEPTH / 2);
        r[3] = ((DEPTH - int'(tx_level)) >= DEPTH / 2);
        return r;
    endfunction

    function automatic logic [7:0] exp_status();
        return {3'b000, busy, rx_level == 4'(DEPTH), rx_level != 0,
                tx_level != 4'(DEPTH), tx_level == 0};
    endfunction

    always @(posedge clk) begin : model
        logic fire, clr;
        if (!rst_n) begin
            m_mask <= '0; m_ovr <= 0; m_tmo <= 0; m_irq <= 0;
            m_act <= 0; m_fired <= 0; m_cnt <= 0;
        end else begin
            fire = 1'b0;
            clr  = reg_we && reg_addr == 3'd3;
            m_irq <= |(exp_raw() & m_mask);
            if (reg_we && reg_addr == 3'd0) m_mask <= reg_wdata[3:0];
            m_ovr <= (rx_frame && rx_level == 4'(DEPTH)) | (m_ovr & ~(clr & reg_wdata[0]));
            if (rx_level == 0) begin
                m_act <= 0; m_fired <= 0; m_cnt <= 0;
            end else if (!m_act) begin
                m_act <= 1; m_fired <= 0; m_cnt <= 0;
            end else if (rx_read || rx_frame) begin
                m_fired <= 0; m_cnt <= 0;
            end else if (!m_fired && bit_tick) begin
                if (m_cnt == TO - 1) begin
                    fire = 1'b1; m_fired <= 1; m_cnt <= 0;
                end else m_cnt <= m_cnt + 1;
            end
            m_tmo <= fire | (m_tmo & ~(clr & reg_wdata[1]));
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.1;
        d = reg_rdata;
    endtask

    task automatic check_all();
        logic [7:0] d;
        logic [3:0] r;
        reg_we = 0;
        r = exp_raw();
        rd(3'd0, d); chk("R1 mask readback", d, {4'b0, m_mask});
        rd(3'd1, d);
        chk("R2 overrun raw", d[0], r[0]);
        chk("R3 timeout raw", d[1], r[1]);
        chk("R4 level flags", d[3:2], r[3:2]);
        chk("R1 raw upper bits", d[7:4], 0);
        rd(3'd2, d); chk("R5 masked", d, {4'b0, r & m_mask});
        rd(3'd3, d); chk("R6 clear reads zero", d, 0);
        rd(3'd4, d); chk("R9 fifo status", d, exp_status());
        chk("R10 irq", irq, m_irq);
    endtask

    task automatic drive(int tx, int rx, bit fr, bit rdp, bit tk, bit bz,
                         bit we, int a, int wd);
        tx_level = 4'(tx); rx_level = 4'(rx); rx_frame = fr; rx_read = rdp;
        bit_tick = tk; busy = bz; reg_we = we; reg_addr = 3'(a); reg_wdata = 8'(wd);
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5a17));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8 reset values
        rd(3'd0, d); chk("R8 mask after reset", d, 0);
        rd(3'd1, d); chk("R8 raw after reset", d, 8'h08);
        rd(3'd2, d); chk("R8 masked after reset", d, 0);
        rd(3'd4, d); chk("R8 status after reset", d, 8'h03);
        chk("R8 irq after reset", irq, 0);

        // overrun set, then R7 collision, then R6 zero write and clear
        drive(0, 8, 1, 0, 0, 0, 0, 0, 0); step();
        rd(3'd1, d); chk("R2 overrun set on full", d[0], 1);
        drive(0, 8, 1, 0, 0, 0, 1, 3, 1); step();
        rd(3'd1, d); chk("R7 set beats clear", d[0], 1);
        drive(0, 8, 0, 0, 0, 0, 1, 3, 0); step();
        rd(3'd1, d); chk("R6 zero write no effect", d[0], 1);
        drive(0, 8, 0, 0, 0, 0, 1, 3, 1); step();
        rd(3'd1, d); chk("R6 clear overrun", d[0], 0);

        // R3 exact timeout edge
        drive(0, 0, 0, 0, 0, 0, 1, 3, 2); step();
        drive(0, 1, 0, 0, 1, 0, 0, 0, 0);
        for (int k = 1; k <= 33; k++) begin
            step();
            drive(0, 1, 0, 0, 1, 0, 0, 0, 0);
            rd(3'd1, d);
            chk("R3 timeout edge", d[1], (k == 33) ? 1 : 0);
            drive(0, 1, 0, 0, 1, 0, 0, 0, 0);
        end
        // mask all, R10 irq lag
        drive(0, 1, 0, 0, 0, 0, 1, 0, 4'hF); step();
        drive(0, 1, 0, 0, 0, 0, 0, 0, 0); step();
        chk("R10 irq asserted", irq, 1);

        // constrained random
        begin
            int tx = 0, rx = 1;
            for (int i = 0; i < 6000; i++) begin
                bit we; int a;
                if ($urandom_range(0, 39) == 0) tx = $urandom_range(0, DEPTH);
                if ($urandom_range(0, 39) == 0) rx = $urandom_range(0, DEPTH);
                we = ($urandom_range(0, 7) == 0);
                a  = $urandom_range(0, 4);
                drive(tx, rx, $urandom_range(0, 29) == 0, $urandom_range(0, 29) == 0,
                      $urandom_range(0, 1), $urandom_range(0, 1), we, a, $urandom_range(0, 255));
                step();
            end
        end
        done = 1;
        summary();
        $finish;
    end
endmodule